// File: doc/BRIEF.md
# Multi-Master Priority Bus Arbiter

This block decides which of four on-chip masters owns a shared internal bus. The masters are a processor, a transfer controller, a DMA engine and an external-DMA engine. Each master raises a request and receives an acknowledge. A master keeps the bus for as long as its acknowledge stays high.

Ownership is never taken from a master mid-operation. The current holder signals, through its own release-point input, the cycles in which it can give up the bus. Only in such a cycle is a new owner chosen, by fixed priority, and the new acknowledge appears on the next clock edge. The processor is the default owner: it holds the bus out of reset and whenever no other master asks for it.

A second stage arbitrates the external bus among four requesters:

- a memory-refresh requester,
- the external-DMA engine's external accesses,
- a request to hand the external bus to an outside agent,
- external accesses by the internal bus holder when that holder is not the external-DMA engine.

This stage also decides when refresh and a non-DRAM access by an internal master may run together. External-DMA external traffic is granted independently of which master holds the internal bus.

Top module: `mba_arbiter_top`

## Requirements
- R1: While reset is asserted, and in the cycles right after it, the acknowledge vector is 4'b0001 (processor, bit 0) and all four external grants are low.
- R2: Exactly one bit of the acknowledge vector is high in every cycle. Bit 0 is the processor, bit 1 the transfer controller, bit 2 the DMA engine and bit 3 the external-DMA engine.
- R3: In a cycle where the release-point input of the current holder is high, the acknowledge on the next edge goes to the highest-numbered requesting master. Bit 3 ranks above bit 2, bit 2 above bit 1, and bit 1 above bit 0.
- R4: While the release-point input of the current holder is low, the acknowledge does not change, whatever the other requests and release-point inputs do.
- R5: At a release point with no request on bits 1 to 3, the acknowledge goes to the processor (bit 0) whether or not the processor requests.
- R6: When no external grant is held, the next external grant goes to the highest pending requester, ranked refresh, then external-DMA, then bus release, then internal-master access. A grant to external-DMA or to bus release is always the only external grant high.
- R7: An external grant stays high while its request stays high, even if a higher-ranked request arrives. It falls on the edge after its request falls.
- R8: With the refresh serial-mode input at 0 and the DRAM-space flag at 0, refresh and an internal-master external access are granted together. Either one may join the other when it is already running.
- R9: With the serial-mode input at 1 or the DRAM-space flag at 1, refresh and an internal-master external access are never granted together. If both are requested from a free bus, or both are held when the condition becomes true, refresh alone is granted.
- R10: The external-DMA external grant can be high while another master holds the internal acknowledge.
- R11: An internal-master external access request is ignored while the external-DMA engine (bit 3) holds the internal acknowledge. No internal-master external grant follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mst_req_i | input | 4 | Bus requests: bit 0 processor, bit 1 transfer controller, bit 2 DMA, bit 3 external-DMA |
| mst_rel_ok_i | input | 4 | Per-master release point: high when that master can give up the bus this cycle |
| mst_ack_o | output | 4 | One-hot bus acknowledge, same bit order as the requests |
| rfsh_req_i | input | 1 | Memory-refresh request |
| rfsh_serial_i | input | 1 | Refresh mode: 1 forbids running refresh alongside internal-master external access |
| xdma_xreq_i | input | 1 | External-DMA external-bus access request |
| xrel_req_i | input | 1 | Request to release the external bus to an outside agent |
| mst_xreq_i | input | 1 | External access request from the current internal holder |
| mst_xdram_i | input | 1 | The internal-master external access targets DRAM space |
| rfsh_gnt_o | output | 1 | Refresh grant |
| xdma_xgnt_o | output | 1 | External-DMA external-bus grant |
| xrel_gnt_o | output | 1 | External bus released to the outside agent |
| mst_xgnt_o | output | 1 | Internal-master external access grant |

## Verification
A corrupted owner register shows at the ports in one of two ways. The acknowledge vector may stop being one-hot. Or it may change in a cycle that followed no release point of the previous holder. Either is visible on the first clock edge after the fault.

A wrong external-stage state shows up on the edge after the offending input pattern. It can appear as an external grant with no request behind it in the previous cycle. It can appear as two grants that the concurrency rule forbids. It can also appear as a held grant that moves to a higher-ranked requester.

A randomized phase compares the acknowledge every cycle against an independent model of the release-point rule.

// File: rtl/mba_pkg.sv
package mba_pkg;
  localparam int N_MST  = 4;
  localparam int MST_CPU = 0;
  localparam int MST_XFR = 1;
  localparam int MST_DMA = 2;
  localparam int MST_XDM = 3;

  localparam int N_XB  = 4;
  localparam int XB_MX = 0;
  localparam int XB_BR = 1;
  localparam int XB_XD = 2;
  localparam int XB_RF = 3;

  typedef logic [N_MST-1:0] mst_vec_t;
  typedef logic [N_XB-1:0]  xb_vec_t;
endpackage

// File: rtl/mba_rst_sync.sv
module mba_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/mba_prio_pick.sv
module mba_prio_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] win
);
  logic [W:0] above;

  assign above[W] = 1'b0;

  genvar i;
  generate
    for (i = W - 1; i >= 0; i--) begin : g_chain
      assign above[i] = above[i+1] | req[i];
      assign win[i]   = req[i] & ~above[i+1];
    end
  endgenerate
endmodule

// File: rtl/mba_int_stage.sv
module mba_int_stage
  import mba_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mst_vec_t req,
  input  mst_vec_t rel_ok,
  output mst_vec_t ack_q
);
  localparam mst_vec_t CPU_ONEHOT = mst_vec_t'(1) << MST_CPU;

  mst_vec_t cand;
  mst_vec_t win;
  mst_vec_t ack_nxt;
  logic     rel_pt;

  // processor is always a candidate so it becomes default owner
  assign cand   = req | CPU_ONEHOT;
  assign rel_pt = |(ack_q & rel_ok);

  mba_prio_pick #(.W(N_MST)) u_pick (
    .req (cand),
    .win (win)
  );

  always_comb begin
    ack_nxt = ack_q;
    if (rel_pt) ack_nxt = win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_q <= CPU_ONEHOT;
    else if (rel_pt) ack_q <= ack_nxt;
  end
endmodule

// File: rtl/mba_ext_stage.sv
module mba_ext_stage
  import mba_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rf_req,
  input  logic    rf_serial,
  input  logic    xd_req,
  input  logic    br_req,
  input  logic    mx_req,
  input  logic    mx_dram,
  input  logic    holder_xdm,
  output xb_vec_t gnt_q
);
  localparam xb_vec_t RF_ONLY = xb_vec_t'(1) << XB_RF;
  localparam xb_vec_t MX_ONLY = xb_vec_t'(1) << XB_MX;
  localparam xb_vec_t RF_MX   = RF_ONLY | MX_ONLY;

  xb_vec_t reqv;
  xb_vec_t held;
  xb_vec_t pick;
  xb_vec_t gnt_nxt;
  logic    mx_eff;
  logic    conc_ok;
  logic    upd_en;

  assign mx_eff  = mx_req & ~holder_xdm;
  assign conc_ok = ~rf_serial & ~mx_dram;

  always_comb begin
    reqv        = '0;
    reqv[XB_RF] = rf_req;
    reqv[XB_XD] = xd_req;
    reqv[XB_BR] = br_req;
    reqv[XB_MX] = mx_eff;
  end

  assign held = gnt_q & reqv;

  mba_prio_pick #(.W(N_XB)) u_pick (
    .req (reqv),
    .win (pick)
  );

  always_comb begin
    if (held != '0) begin
      gnt_nxt = held;
      if (gnt_nxt == RF_MX && !conc_ok) gnt_nxt = RF_ONLY;
      if (gnt_nxt == RF_ONLY && mx_eff && conc_ok) gnt_nxt = RF_MX;
      if (gnt_nxt == MX_ONLY && rf_req && conc_ok) gnt_nxt = RF_MX;
    end else begin
      gnt_nxt = pick;
      if (gnt_nxt == RF_ONLY && mx_eff && conc_ok) gnt_nxt = RF_MX;
    end
  end

  assign upd_en = (gnt_nxt != gnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gnt_q <= '0;
    else if (upd_en) gnt_q <= gnt_nxt;
  end
endmodule

// File: rtl/mba_arbiter_top.sv
module mba_arbiter_top
  import mba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mst_req_i,
  input  logic [3:0] mst_rel_ok_i,
  output logic [3:0] mst_ack_o,
  input  logic       rfsh_req_i,
  input  logic       rfsh_serial_i,
  input  logic       xdma_xreq_i,
  input  logic       xrel_req_i,
  input  logic       mst_xreq_i,
  input  logic       mst_xdram_i,
  output logic       rfsh_gnt_o,
  output logic       xdma_xgnt_o,
  output logic       xrel_gnt_o,
  output logic       mst_xgnt_o
);
  logic     rst_sync_n;
  mst_vec_t ack_q;
  xb_vec_t  xgnt_q;

  mba_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mba_int_stage u_int (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .req    (mst_req_i),
    .rel_ok (mst_rel_ok_i),
    .ack_q  (ack_q)
  );

  mba_ext_stage u_ext (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rf_req     (rfsh_req_i),
    .rf_serial  (rfsh_serial_i),
    .xd_req     (xdma_xreq_i),
    .br_req     (xrel_req_i),
    .mx_req     (mst_xreq_i),
    .mx_dram    (mst_xdram_i),
    .holder_xdm (ack_q[MST_XDM]),
    .gnt_q      (xgnt_q)
  );

  assign mst_ack_o   = ack_q;
  assign rfsh_gnt_o  = xgnt_q[XB_RF];
  assign xdma_xgnt_o = xgnt_q[XB_XD];
  assign xrel_gnt_o  = xgnt_q[XB_BR];
  assign mst_xgnt_o  = xgnt_q[XB_MX];
endmodule

// File: rtl/mba_arbiter_chk.sv
module mba_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mst_rel_ok_i,
  input logic [3:0] mst_ack_o,
  input logic       rfsh_req_i,
  input logic       rfsh_serial_i,
  input logic       xdma_xreq_i,
  input logic       xrel_req_i,
  input logic       mst_xreq_i,
  input logic       mst_xdram_i,
  input logic       rfsh_gnt_o,
  input logic       xdma_xgnt_o,
  input logic       xrel_gnt_o,
  input logic       mst_xgnt_o
);
  // R2
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mst_ack_o) == 1);

  // R4
  ack_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_ack_o != $past(mst_ack_o)) |-> $past(|(mst_rel_ok_i & mst_ack_o)));

  // R6
  xdma_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xdma_xgnt_o |-> !(rfsh_gnt_o || xrel_gnt_o || mst_xgnt_o));

  // R6
  xrel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xrel_gnt_o |-> !(rfsh_gnt_o || xdma_xgnt_o || mst_xgnt_o));

  // R7
  rfsh_had_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_gnt_o |-> $past(rfsh_req_i));

  // R7
  xrel_had_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xrel_gnt_o |-> $past(xrel_req_i));

  // R7
  xdma_had_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xdma_xgnt_o |-> $past(xdma_xreq_i));

  // R9
  pair_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_gnt_o && mst_xgnt_o) |-> $past(!rfsh_serial_i && !mst_xdram_i));

  // R11
  mx_not_xdm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_xgnt_o |-> $past(mst_xreq_i && !mst_ack_o[3]));
endmodule

bind mba_arbiter_top mba_arbiter_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mst_rel_ok_i  (mst_rel_ok_i),
  .mst_ack_o     (mst_ack_o),
  .rfsh_req_i    (rfsh_req_i),
  .rfsh_serial_i (rfsh_serial_i),
  .xdma_xreq_i   (xdma_xreq_i),
  .xrel_req_i    (xrel_req_i),
  .mst_xreq_i    (mst_xreq_i),
  .mst_xdram_i   (mst_xdram_i),
  .rfsh_gnt_o    (rfsh_gnt_o),
  .xdma_xgnt_o   (xdma_xgnt_o),
  .xrel_gnt_o    (xrel_gnt_o),
  .mst_xgnt_o    (mst_xgnt_o)
);

// File: tb/mba_arbiter_top_tb_top.sv
`timescale 1ns/1ps
module mba_arbiter_top_tb_top;
  logic       clk;
  logic       rst_n;
  logic [3:0] req;
  logic [3:0] rel;
  logic [3:0] ack;
  logic       rf, ser, xd, br, mx, dram;
  logic       g_rf, g_xd, g_br, g_mx;

  int checks;
  int fails;
  bit done;

  mba_arbiter_top dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mst_req_i     (req),
    .mst_rel_ok_i  (rel),
    .mst_ack_o     (ack),
    .rfsh_req_i    (rf),
    .rfsh_serial_i (ser),
    .xdma_xreq_i   (xd),
    .xrel_req_i    (br),
    .mst_xreq_i    (mx),
    .mst_xdram_i   (dram),
    .rfsh_gnt_o    (g_rf),
    .xdma_xgnt_o   (g_xd),
    .xrel_gnt_o    (g_br),
    .mst_xgnt_o    (g_mx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // rows: {req[3:0], rel[3:0], expected ack[3:0]}, applied one per cycle from reset
  localparam logic [11:0] VEC [12] = '{
    12'b0000_0000_0001,  // R5 nothing requested
    12'b0010_0000_0001,  // R4 no release point
    12'b0010_0001_0010,  // R3 handover to transfer ctl
    12'b1010_0001_0010,  // R4 release of non-holder ignored
    12'b1110_0010_1000,  // R3 ext-DMA wins
    12'b0110_0000_1000,  // R4 hold
    12'b0110_1000_0100,  // R3 DMA over transfer ctl
    12'b0111_0100_0100,  // R3 holder still highest
    12'b0011_0100_0010,  // R3
    12'b0001_0010_0001,  // R5
    12'b1000_0001_1000,  // R3
    12'b0000_1000_0001   // R5 back to default owner
  };

  function automatic logic [3:0] xg();
    return {g_rf, g_xd, g_br, g_mx};
  endfunction

  function automatic logic [3:0] model_ack(logic [3:0] cur, logic [3:0] rq, logic [3:0] ro);
    if ((cur & ro) == 4'b0) return cur;
    if (rq[3]) return 4'b1000;
    if (rq[2]) return 4'b0100;
    if (rq[1]) return 4'b0010;
    return 4'b0001;
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic setx(logic a, logic s, logic d, logic b, logic m, logic r);
    rf = a; ser = s; xd = d; br = b; mx = m; dram = r;
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; req = '0; rel = '0;
    setx(0, 0, 0, 0, 0, 0);
    repeat (3) step();
    chk("R1 ack in reset", ack, 4'b0001);
    chk("R1 ext grants in reset", xg(), 4'b0000);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 ack after reset", ack, 4'b0001);
    chk("R1 ext grants after reset", xg(), 4'b0000);

    foreach (VEC[i]) begin
      req = VEC[i][11:8];
      rel = VEC[i][7:4];
      step();
      chk($sformatf("R3/R4/R5 row %0d", i), ack, VEC[i][3:0]);
    end
    req = '0; rel = '0;

    // external stage, processor holds internal bus
    setx(1, 0, 1, 1, 0, 0); step();
    chk("R6 refresh first", xg(), 4'b1000);
    setx(0, 0, 1, 1, 0, 0); step();
    chk("R6 ext-DMA next", xg(), 4'b0100);
    chk("R10 ext-DMA while processor holds", ack, 4'b0001);
    setx(1, 0, 1, 1, 0, 0); step();
    chk("R7 ext-DMA kept over refresh", xg(), 4'b0100);
    setx(1, 0, 0, 1, 0, 0); step();
    chk("R7 refresh after ext-DMA drops", xg(), 4'b1000);
    setx(0, 0, 0, 1, 0, 0); step();
    chk("R6 bus release", xg(), 4'b0010);
    setx(0, 0, 0, 1, 1, 0); step();
    chk("R7 release kept over master access", xg(), 4'b0010);
    setx(0, 0, 0, 0, 1, 0); step();
    chk("R6 master access last", xg(), 4'b0001);
    setx(0, 0, 0, 0, 0, 0); step();
    chk("R7 grants drop", xg(), 4'b0000);

    setx(1, 0, 0, 0, 1, 0); step();
    chk("R8 refresh with non-DRAM access", xg(), 4'b1001);
    setx(1, 1, 0, 0, 1, 0); step();
    chk("R9 serial mode splits pair", xg(), 4'b1000);
    setx(0, 0, 0, 0, 0, 0); step();
    setx(1, 0, 0, 0, 1, 1); step();
    chk("R9 DRAM target refresh wins", xg(), 4'b1000);
    setx(0, 0, 0, 0, 0, 0); step();
    setx(0, 0, 0, 0, 1, 0); step();
    chk("R8 access alone", xg(), 4'b0001);
    setx(1, 0, 0, 0, 1, 0); step();
    chk("R8 refresh joins access", xg(), 4'b1001);
    setx(0, 0, 0, 0, 0, 0); step();

    req = 4'b1000; rel = 4'b0001; step();
    chk("R11 ext-DMA holds internal bus", ack, 4'b1000);
    rel = 4'b0000; setx(0, 0, 0, 0, 1, 0); step();
    chk("R11 master access ignored", xg(), 4'b0000);
    step();
    chk("R11 master access still ignored", xg(), 4'b0000);
    setx(0, 0, 0, 0, 0, 0); req = 4'b0000; rel = 4'b1000; step();
    chk("R5 default owner restored", ack, 4'b0001);

    // randomized simultaneous requests against the model
    begin
      logic [3:0] exp;
      exp = ack;
      for (int n = 0; n < 300; n++) begin
        req = 4'($urandom);
        rel = 4'($urandom);
        exp = model_ack(exp, req, rel);
        step();
        chk("R2/R3/R4 random", ack, exp);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule